// File: doc/BRIEF.md
# Horizontal Video Line Resampler

This block takes one video line at a time as a stream of 8-bit samples and produces a new line whose length is set by a per-line output count. Either side of the block can pause the stream with a valid/ready handshake. It works in two stages. First, an averaging stage sums each run of N consecutive input samples and divides the sum, rounded, by N. This keeps aliasing down when a line is shrunk a great deal. Second, an interpolation stage places each output sample on the averaged sequence at a position held as a fixed-point number with 6 fractional bits. It then blends the two neighbouring averaged samples in proportion to the fractional part.

Two parameter sets, A and B, are applied through input pins. A field-start pulse samples the set-select pin, and that choice holds until the next field start. A line-start pulse does three things: it latches the chosen set for the new line, drops any partly summed group, and reloads the starting phase. After the programmed number of outputs, the block keeps accepting the rest of the line's input and produces nothing from it.

Top module: `hscaler`

## Requirements
- R1: After reset, and until the first line start, `out_valid_o` is 0 and `in_ready_o` is 1. Samples offered in this period are accepted and produce no output.
- R2: The averaged sequence is f[k] = (x[kN] + … + x[kN+N−1] + floor(N/2)) / N, using integer division. N is the set's length field: a value of 0 acts as 1, and values above 64 act as 64.
- R3: Output j lies at pos = phase0 + j·inc, where inc has 6 fractional bits and phase0 is the 6-bit starting phase. With i = pos>>6 and p = pos mod 64, the output is (f[i]·(64−p) + f[i+1]·p + 32) >> 6, limited to 255.
- R4: Increments from 32 (2× zoom) up to 128 give results that follow R3. Combined with N = 64 and an increment of 64, the line is shrunk to 1/64.
- R5: A `field_start_i` pulse samples `set_sel_i` (0 selects set A, 1 selects set B). A change on `set_sel_i` without a field start has no effect. When a field start and a line start occur in the same cycle, that line uses the newly selected set.
- R6: In the cycle when `line_start_i` is high, `in_ready_o` is 0. The line start discards any partial group, so the samples before it contribute nothing to the new line.
- R7: Gaps in `in_valid_i` and stalls on `out_ready_i` do not change the output values or their number.
- R8: A line produces exactly the programmed output count and then accepts the rest of its input with no output. A count of 0 gives no output.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the next cycle keeps `out_valid_o` high with `out_data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| field_start_i | input | 1 | Field boundary pulse; samples set_sel_i |
| set_sel_i | input | 1 | Parameter set choice (0 = A, 1 = B) |
| line_start_i | input | 1 | Line start pulse |
| cfg_a_inc_i | input | 13 | Set A position increment, 7.6 fixed point |
| cfg_a_len_i | input | 7 | Set A averaging length N |
| cfg_a_phase_i | input | 6 | Set A starting phase |
| cfg_a_cnt_i | input | 11 | Set A outputs per line |
| cfg_b_inc_i | input | 13 | Set B position increment, 7.6 fixed point |
| cfg_b_len_i | input | 7 | Set B averaging length N |
| cfg_b_phase_i | input | 6 | Set B starting phase |
| cfg_b_cnt_i | input | 11 | Set B outputs per line |
| in_valid_i | input | 1 | Input sample valid |
| in_data_i | input | 8 | Input sample |
| in_ready_o | output | 1 | Input sample accepted when high |
| out_valid_o | output | 1 | Output sample valid |
| out_data_o | output | 8 | Output sample |
| out_ready_i | input | 1 | Downstream accepts output |

## Verification
If the group counter or the sum is wrong, every sample after the first affected averaged value shifts. If the advance counter is off by one, each later output pairs the wrong neighbours, and the error shows on the next output transfer. A bad output counter changes the number of outputs per line, which shows at line end. A set-select register that does not hold gives a wrong increment on the line after the field boundary. Sweeping all 64 phases and every increment from 32 to 128 against the arithmetic model, with gaps and stalls, catches each of these within one line.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;
  parameter int DW      = 8;
  parameter int PHW     = 6;
  parameter int INTW    = 7;
  parameter int LENW    = 7;
  parameter int CNTW    = 11;
  localparam int INCW    = INTW + PHW;
  localparam int ADVW    = INTW + 1;
  localparam int ACC_MAX = 1 << PHW;
  localparam int ACCW    = DW + PHW;
  localparam int MAXV    = (1 << DW) - 1;

  typedef struct packed {
    logic [INCW-1:0] inc;
    logic [LENW-1:0] len;
    logic [PHW-1:0]  phase;
    logic [CNTW-1:0] cnt;
  } cfg_t;
endpackage

// File: rtl/hs_set_sel.sv
`timescale 1ns/1ps
module hs_set_sel
  import hs_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            field_start_i,
  input  logic            set_sel_i,
  input  logic            line_start_i,
  input  cfg_t            cfg_a_i,
  input  cfg_t            cfg_b_i,
  output logic [PHW-1:0]  start_phase_o,
  output logic [CNTW-1:0] start_cnt_o,
  output logic [INCW-1:0] line_inc_o,
  output logic [LENW-1:0] line_len_o,
  output logic [CNTW-1:0] line_cnt_o
);
  logic            act_q, sel_nxt;
  cfg_t            sel_cfg;
  logic [INCW-1:0] inc_q;
  logic [LENW-1:0] len_q;
  logic [CNTW-1:0] cnt_q;

  // field start takes effect in the same cycle so a coincident line start sees it
  assign sel_nxt = field_start_i ? set_sel_i : act_q;

  always_comb begin
    sel_cfg = sel_nxt ? cfg_b_i : cfg_a_i;
    if (sel_cfg.len == '0)                     sel_cfg.len = LENW'(1);
    else if (sel_cfg.len > LENW'(ACC_MAX))     sel_cfg.len = LENW'(ACC_MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      inc_q <= '0;
      len_q <= LENW'(1);
      cnt_q <= '0;
    end else begin
      act_q <= sel_nxt;
      if (line_start_i) begin
        inc_q <= sel_cfg.inc;
        len_q <= sel_cfg.len;
        cnt_q <= sel_cfg.cnt;
      end
    end
  end

  assign start_phase_o = sel_cfg.phase;
  assign start_cnt_o   = sel_cfg.cnt;
  assign line_inc_o    = inc_q;
  assign line_len_o    = len_q;
  assign line_cnt_o    = cnt_q;

  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_q >= LENW'(1)) && (len_q <= LENW'(ACC_MAX))); // R2
  AST_SET_SAMPLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_start_i |=> (act_q == $past(set_sel_i))); // R5
endmodule

// File: rtl/hs_prefilter.sv
`timescale 1ns/1ps
module hs_prefilter
  import hs_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            line_start_i,
  input  logic [LENW-1:0] len_i,
  input  logic            acc_en_i,
  input  logic [DW-1:0]   data_i,
  output logic            f_valid_o,
  output logic [DW-1:0]   f_data_o
);
  localparam int SW = ACCW + 1;

  logic [ACCW-1:0] acc_q;
  logic [LENW-1:0] grp_q;
  logic [SW-1:0]   tot, num, quo;
  logic            last;

  assign last = (grp_q == len_i - LENW'(1));
  assign tot  = SW'(acc_q) + SW'(data_i);
  assign num  = tot + SW'(len_i >> 1);
  assign quo  = num / SW'(len_i);
  assign f_data_o  = (quo > SW'(MAXV)) ? DW'(MAXV) : quo[DW-1:0];
  assign f_valid_o = acc_en_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      grp_q <= '0;
    end else if (line_start_i) begin
      acc_q <= '0;
      grp_q <= '0;
    end else if (acc_en_i) begin
      if (last) begin
        acc_q <= '0;
        grp_q <= '0;
      end else begin
        acc_q <= tot[ACCW-1:0];
        grp_q <= grp_q + LENW'(1);
      end
    end
  end

  AST_ACC_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_en_i && !line_start_i) |=> ($stable(acc_q) && $stable(grp_q))); // R7
  AST_LINE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> (grp_q == '0 && acc_q == '0)); // R6
  AST_AVG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_valid_o |-> (quo <= SW'(MAXV))); // R2
endmodule

// File: rtl/hs_interp.sv
`timescale 1ns/1ps
module hs_interp
  import hs_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            line_start_i,
  input  logic [PHW-1:0]  start_phase_i,
  input  logic [CNTW-1:0] start_cnt_i,
  input  logic [INCW-1:0] inc_i,
  input  logic [CNTW-1:0] cnt_i,
  input  logic            f_valid_i,
  input  logic [DW-1:0]   f_data_i,
  input  logic            out_ready_i,
  output logic            out_valid_o,
  output logic [DW-1:0]   out_data_o,
  output logic            need_o,
  output logic            done_o
);
  localparam int PW = DW + PHW + 1;

  logic [DW-1:0]   a_q, b_q, od_q;
  logic [PHW-1:0]  p_q;
  logic [ADVW-1:0] adv_q;
  logic [CNTW-1:0] ocnt_q, ocnt_nxt;
  logic            done_q, ov_q, emit;
  logic [INCW:0]   step;
  logic [PHW:0]    wa, wb;
  logic [PW-1:0]   mix, rnd;
  logic [DW-1:0]   res;

  assign need_o   = !done_q && (adv_q != '0);
  assign done_o   = done_q;
  assign emit     = !done_q && (adv_q == '0) && (!ov_q || out_ready_i) && !line_start_i;
  assign ocnt_nxt = ocnt_q + CNTW'(1);
  // carry out of the fraction feeds the advance count
  assign step     = (INCW+1)'(p_q) + (INCW+1)'(inc_i);

  assign wb  = {1'b0, p_q};
  assign wa  = (PHW+1)'(ACC_MAX) - wb;
  assign mix = PW'(a_q) * PW'(wa) + PW'(b_q) * PW'(wb) + PW'(ACC_MAX / 2);
  assign rnd = mix >> PHW;
  assign res = (rnd > PW'(MAXV)) ? DW'(MAXV) : rnd[DW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      p_q    <= '0;
      adv_q  <= '0;
      ocnt_q <= '0;
      done_q <= 1'b1;
    end else if (line_start_i) begin
      adv_q  <= ADVW'(2);
      p_q    <= start_phase_i;
      ocnt_q <= '0;
      done_q <= (start_cnt_i == '0);
    end else if (emit) begin
      {adv_q, p_q} <= step;
      ocnt_q <= ocnt_nxt;
      done_q <= (ocnt_nxt == cnt_i);
    end else if (f_valid_i && need_o) begin
      a_q   <= b_q;
      b_q   <= f_data_i;
      adv_q <= adv_q - ADVW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else if (emit) begin
      ov_q <= 1'b1;
      od_q <= res;
    end else if (out_ready_i) begin
      ov_q <= 1'b0;
    end
  end

  assign out_valid_o = ov_q;
  assign out_data_o  = od_q;

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_q && !out_ready_i) |=> (ov_q && $stable(od_q))); // R9
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !line_start_i) |=> $stable(ocnt_q)); // R8
  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ocnt_q <= cnt_i); // R8
  AST_ADV_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!f_valid_i && !emit && !line_start_i) |=> ($stable(adv_q) && $stable(p_q))); // R7
endmodule

// File: rtl/hscaler.sv
`timescale 1ns/1ps
module hscaler
  import hs_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            field_start_i,
  input  logic            set_sel_i,
  input  logic            line_start_i,
  input  logic [INCW-1:0] cfg_a_inc_i,
  input  logic [LENW-1:0] cfg_a_len_i,
  input  logic [PHW-1:0]  cfg_a_phase_i,
  input  logic [CNTW-1:0] cfg_a_cnt_i,
  input  logic [INCW-1:0] cfg_b_inc_i,
  input  logic [LENW-1:0] cfg_b_len_i,
  input  logic [PHW-1:0]  cfg_b_phase_i,
  input  logic [CNTW-1:0] cfg_b_cnt_i,
  input  logic            in_valid_i,
  input  logic [DW-1:0]   in_data_i,
  output logic            in_ready_o,
  output logic            out_valid_o,
  output logic [DW-1:0]   out_data_o,
  input  logic            out_ready_i
);
  cfg_t            cfg_a, cfg_b;
  logic [PHW-1:0]  start_phase;
  logic [CNTW-1:0] start_cnt, line_cnt;
  logic [INCW-1:0] line_inc;
  logic [LENW-1:0] line_len;
  logic            acc_en, f_valid, need, done;
  logic [DW-1:0]   f_data;

  assign cfg_a = '{inc: cfg_a_inc_i, len: cfg_a_len_i, phase: cfg_a_phase_i, cnt: cfg_a_cnt_i};
  assign cfg_b = '{inc: cfg_b_inc_i, len: cfg_b_len_i, phase: cfg_b_phase_i, cnt: cfg_b_cnt_i};

  // stall input once the window is full for the next output; drain freely when done
  assign in_ready_o = !line_start_i && (done || need);
  assign acc_en     = in_valid_i && in_ready_o;

  hs_set_sel u_sel (
    .clk_i, .rst_ni, .field_start_i, .set_sel_i, .line_start_i,
    .cfg_a_i(cfg_a), .cfg_b_i(cfg_b),
    .start_phase_o(start_phase), .start_cnt_o(start_cnt),
    .line_inc_o(line_inc), .line_len_o(line_len), .line_cnt_o(line_cnt)
  );

  hs_prefilter u_pre (
    .clk_i, .rst_ni, .line_start_i,
    .len_i(line_len), .acc_en_i(acc_en), .data_i(in_data_i),
    .f_valid_o(f_valid), .f_data_o(f_data)
  );

  hs_interp u_int (
    .clk_i, .rst_ni, .line_start_i,
    .start_phase_i(start_phase), .start_cnt_i(start_cnt),
    .inc_i(line_inc), .cnt_i(line_cnt),
    .f_valid_i(f_valid), .f_data_i(f_data), .out_ready_i,
    .out_valid_o, .out_data_o, .need_o(need), .done_o(done)
  );

  AST_NO_OUT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !line_start_i && !out_valid_o) |=> !out_valid_o); // R8
endmodule

// File: tb/tb_hscaler.sv
`timescale 1ns/1ps
module tb_hscaler;
  import hs_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, field_start_i, set_sel_i, line_start_i;
  logic [INCW-1:0] a_inc, b_inc;
  logic [LENW-1:0] a_len, b_len;
  logic [PHW-1:0]  a_ph, b_ph;
  logic [CNTW-1:0] a_cnt, b_cnt;
  logic in_valid_i, in_ready_o, out_valid_o, out_ready_i;
  logic [DW-1:0] in_data_i, out_data_o;

  hscaler dut (
    .clk_i(clk), .rst_ni(rst_n), .field_start_i, .set_sel_i, .line_start_i,
    .cfg_a_inc_i(a_inc), .cfg_a_len_i(a_len), .cfg_a_phase_i(a_ph), .cfg_a_cnt_i(a_cnt),
    .cfg_b_inc_i(b_inc), .cfg_b_len_i(b_len), .cfg_b_phase_i(b_ph), .cfg_b_cnt_i(b_cnt),
    .in_valid_i, .in_data_i, .in_ready_o, .out_valid_o, .out_data_o, .out_ready_i
  );

  int checks = 0, errors = 0;
  int xin[0:1023];
  int got[0:1023];
  int ngot = 0;
  bit bp = 0, gaps = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  always @(negedge clk) out_ready_i = bp ? lfsr[0] : 1'b1;

  bit pv = 0;
  int pd = 0;
  always @(negedge clk) begin
    #2;
    if (pv) chk(out_valid_o && (int'(out_data_o) == pd), "R9 hold", int'(out_data_o), pd);
    if (out_valid_o && out_ready_i) begin
      got[ngot] = int'(out_data_o);
      ngot++;
    end
    pv = out_valid_o && !out_ready_i;
    pd = int'(out_data_o);
  end

  function automatic int filt(input int k, input int n);
    int s = 0;
    for (int t = 0; t < n; t++) s += xin[k*n + t];
    return (s + n/2) / n;
  endfunction

  function automatic int exp_out(input int j, input int inc, input int n, input int ph);
    int pos = ph + j*inc;
    int i = pos >> 6;
    int p = pos & 63;
    int v = (filt(i, n)*(64 - p) + filt(i+1, n)*p + 32) >> 6;
    return (v > 255) ? 255 : v;
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < 1024; i++) xin[i] = (i*37 + seed*53 + (i*i) % 11) & 255;
  endtask

  task automatic send(input int n);
    int idx = 0;
    while (idx < n) begin
      @(negedge clk);
      in_valid_i = gaps ? lfsr[3] : 1'b1;
      in_data_i  = DW'(xin[idx]);
      #1;
      if (in_valid_i && in_ready_o) idx++;
    end
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic set_a(input int inc, input int len, input int ph, input int cnt);
    a_inc = INCW'(inc); a_len = LENW'(len); a_ph = PHW'(ph); a_cnt = CNTW'(cnt);
  endtask

  task automatic set_b(input int inc, input int len, input int ph, input int cnt);
    b_inc = INCW'(inc); b_len = LENW'(len); b_ph = PHW'(ph); b_cnt = CNTW'(cnt);
  endtask

  task automatic pulse_line(input bit fld, input bit fsel);
    @(negedge clk);
    line_start_i = 1'b1;
    if (fld) begin field_start_i = 1'b1; set_sel_i = fsel; end
    #1 chk(in_ready_o == 1'b0, "R6 ready low at line start", int'(in_ready_o), 0);
    @(negedge clk);
    line_start_i = 1'b0;
    field_start_i = 1'b0;
  endtask

  task automatic run_line(input int n_in, input int inc, input int len, input int ph,
                          input int cnt, input string req, input bit fld = 0, input bit fsel = 0);
    int ne = (len == 0) ? 1 : ((len > 64) ? 64 : len);
    ngot = 0;
    pulse_line(fld, fsel);
    send(n_in);
    repeat (30) @(negedge clk);
    chk(ngot == cnt, {req, " count"}, ngot, cnt);
    for (int j = 0; j < cnt && j < ngot; j++) begin
      int e = exp_out(j, inc, ne, ph);
      chk(got[j] == e, req, got[j], e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; field_start_i = 1'b0; set_sel_i = 1'b0; line_start_i = 1'b0;
    in_valid_i = 1'b0; in_data_i = '0;
    set_a(64, 1, 0, 4); set_b(64, 1, 0, 4);
    fill(1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state and pre-line draining
    chk(out_valid_o == 1'b0, "R1 out_valid after reset", int'(out_valid_o), 0);
    chk(in_ready_o == 1'b1, "R1 in_ready after reset", int'(in_ready_o), 1);
    ngot = 0;
    send(5);
    repeat (10) @(negedge clk);
    chk(ngot == 0, "R1 no output before line", ngot, 0);

    // R3: every phase, unity step
    for (int ph = 0; ph < 64; ph++) begin
      fill(ph);
      set_a(64, 1, ph, 2);
      run_line(4, 64, 1, ph, 2, "R3 phase sweep");
    end

    // R4/R7: increments 32..128 with gaps and stalls
    gaps = 1; bp = 1;
    for (int inc = 32; inc <= 128; inc++) begin
      fill(inc);
      set_a(inc, 1, 7, 8);
      run_line(((7 + 7*inc) >> 6) + 3, inc, 1, 7, 8, "R4 R7 inc sweep");
    end

    // R2: averaging lengths, clamps and saturation
    fill(3);
    set_a(80, 3, 63, 6);   run_line(30, 80, 3, 63, 6, "R2 len3");
    set_a(40, 2, 33, 12);  run_line(24, 40, 2, 33, 12, "R2 len2");
    set_a(64, 4, 0, 8);    run_line(40, 64, 4, 0, 8, "R2 len4");
    set_a(64, 0, 0, 4);    run_line(8, 64, 0, 0, 4, "R2 len0 clamp");
    set_a(64, 100, 0, 1);  run_line(128, 64, 100, 0, 1, "R2 len100 clamp");
    set_a(64, 64, 0, 2);   run_line(192, 64, 64, 0, 2, "R4 icon 1/64");
    for (int i = 0; i < 1024; i++) xin[i] = 255;
    set_a(96, 5, 17, 4);   run_line(40, 96, 5, 17, 4, "R3 full-scale clip");

    // R8: stop after count, leftover consumed, zero count
    fill(9);
    set_a(64, 1, 0, 5);    run_line(20, 64, 1, 0, 5, "R8 stop early");
    set_a(64, 1, 0, 0);    run_line(8, 64, 1, 0, 0, "R8 zero count");

    // R5: set selection
    gaps = 0; bp = 0;
    fill(12);
    set_a(64, 1, 0, 4); set_b(128, 1, 0, 3);
    @(negedge clk); field_start_i = 1'b1; set_sel_i = 1'b1;
    @(negedge clk); field_start_i = 1'b0;
    run_line(10, 128, 1, 0, 3, "R5 set B");
    set_sel_i = 1'b0;
    run_line(10, 128, 1, 0, 3, "R5 sel without field");
    run_line(10, 64, 1, 0, 4, "R5 field with line", 1, 0);

    // R6: partial group discarded at line start
    set_a(64, 4, 0, 3);
    ngot = 0;
    pulse_line(0, 0);
    send(3);
    repeat (10) @(negedge clk);
    chk(ngot == 0, "R6 partial group no output", ngot, 0);
    fill(20);
    run_line(16, 64, 4, 0, 3, "R6 after restart");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule